// File: doc/BRIEF.md
# Segment Access Protection Checker

This block takes one memory access expressed as an offset into a segment and produces the linear address of that access. It also decides whether the access is permitted. The segment description is presented on input pins together with the request: base, limit, descriptor privilege and the read, write and execute permission bits. The selector's requested privilege, the core's current privilege, the operation type and a legacy-mode select come in on the same pins. Table lookup and fault delivery are left to the surrounding logic.

Requests arrive over a valid/ready handshake. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. The result is registered at that edge and appears on the response pins in the following cycle, with `rsp_valid` high. The response register holds one result. `req_ready` is high when that register is empty or is being drained in the same cycle (`rsp_ready` high). While `rsp_valid` is high and `rsp_ready` is low, the response stays unchanged and no new request is taken.

In legacy mode, the 16-bit base is shifted left by four and the 16-bit offset is added to it, giving a 20-bit address. No checks apply in this mode. In protected mode, the base and the offset are added, and three checks decide the outcome: the limit, the privilege and the permission bits.

Top module: `seg_prot_checker`

## Requirements
- R1: In protected mode (`real_mode`=0), `rsp_addr` equals `desc_base + req_offset` modulo 2^32.
- R2: In legacy mode (`real_mode`=1), `rsp_addr` is (`desc_base[15:0]`*16 + `req_offset[15:0]`) modulo 2^20, zero-extended to 32 bits. The grant is always given with fault code 00, whatever the limit, privilege, permissions and upper offset bits are.
- R3: Protected-mode privilege passes only when max(`cur_pl`, `sel_rpl`) <= `desc_dpl`. Level 0 is the most trusted. A failure gives fault code 10.
- R4: `acc_type` is encoded 00 read, 01 write, 10 execute and 11 reserved. `desc_perm` bit 0 allows read, bit 1 allows write and bit 2 allows execute. An operation whose bit is clear, or the reserved type, gives fault code 11.
- R5: An offset strictly greater than `desc_limit` gives fault code 01. An offset equal to the limit is inside the segment.
- R6: When several checks fail, the fault reported is chosen in this order: limit (01) first, then privilege (10), then permission (11).
- R7: `rsp_grant` is high exactly when `rsp_fault` is 00. The address is produced even when the access is denied.
- R8: A request accepted at a clock edge has its result on the response pins with `rsp_valid` high from that edge on. `req_ready` = !`rsp_valid` || `rsp_ready`.
- R9: While `rsp_valid`=1 and `rsp_ready`=0, the response pins are held stable and `req_ready` is low.
- R10: After reset, `rsp_valid`=0, `rsp_grant`=0, `rsp_fault`=00 and `req_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| real_mode | input | 1 | 1 selects legacy shifted-base mode |
| desc_base | input | 32 | Segment base |
| desc_limit | input | 32 | Highest valid offset |
| desc_dpl | input | 2 | Descriptor privilege level |
| desc_perm | input | 3 | Permission bits {exec, write, read} |
| sel_rpl | input | 2 | Requested privilege level from the selector |
| cur_pl | input | 2 | Current privilege level |
| acc_type | input | 2 | Operation: 00 read, 01 write, 10 execute, 11 reserved |
| req_offset | input | 32 | Offset within the segment |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_addr | output | 32 | Linear address |
| rsp_grant | output | 1 | Access allowed |
| rsp_fault | output | 2 | 00 ok, 01 limit, 10 privilege, 11 permission |

## Verification
Some properties are checked on every cycle:
- the one-cycle latency after acceptance;
- the held response under back-pressure;
- agreement between the grant and the fault code;
- the protected-mode sum and the legacy-mode grant;
- the precedence of the limit fault;
- the max rule in the privilege comparator.

The bench's scenarios cover the rest:
- the full combinations of privilege and permission outcomes;
- the 20-bit and 32-bit wrap values;
- the exact limit boundary;
- a second request refused while the response is stalled.

// File: rtl/segchk_pkg.sv
package segchk_pkg;
  localparam int PERM_W = 3;
  localparam int PERM_RD = 0;
  localparam int PERM_WR = 1;
  localparam int PERM_EX = 2;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_EXEC  = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_e;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'b00,
    FLT_LIMIT  = 2'b01,
    FLT_PRIV   = 2'b10,
    FLT_RIGHTS = 2'b11
  } fault_e;
endpackage

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
  parameter int ADDR_W   = 32,
  parameter int RM_SEG_W = 16,
  parameter int RM_SHIFT = 4
) (
  input  logic              real_mode,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] offset,
  output logic [ADDR_W-1:0] lin_addr
);
  localparam int RM_ADDR_W = RM_SEG_W + RM_SHIFT;

  logic [RM_ADDR_W-1:0] rm_sum;
  logic [ADDR_W-1:0]    pm_sum;
  logic [ADDR_W-1:0]    rm_ext;

  // legacy: shifted 16-bit base plus 16-bit offset, wraps at RM_ADDR_W bits
  assign rm_sum = {base[RM_SEG_W-1:0], {RM_SHIFT{1'b0}}}
                + {{RM_SHIFT{1'b0}}, offset[RM_SEG_W-1:0]};
  // protected: full-width sum, wraps modulo 2^ADDR_W
  assign pm_sum = base + offset;

  generate
    if (ADDR_W > RM_ADDR_W) begin : g_ext
      assign rm_ext = {{(ADDR_W-RM_ADDR_W){1'b0}}, rm_sum};
    end else begin : g_trunc
      assign rm_ext = rm_sum[ADDR_W-1:0];
    end
  endgenerate

  assign lin_addr = real_mode ? rm_ext : pm_sum;
endmodule

// File: rtl/seg_priv_check.sv
module seg_priv_check #(
  parameter int PL_W = 2
) (
  input  logic [PL_W-1:0] rpl,
  input  logic [PL_W-1:0] cpl,
  input  logic [PL_W-1:0] dpl,
  output logic            priv_ok
);
  logic [PL_W-1:0] eff_pl;

  // the less trusted (numerically larger) of the two levels governs
  assign eff_pl  = (rpl > cpl) ? rpl : cpl;
  assign priv_ok = (eff_pl <= dpl);

  // R3: a pass means both levels are individually within the descriptor level
  always_comb begin
    p_priv_max_r3: assert (!priv_ok || ((rpl <= dpl) && (cpl <= dpl)));
  end
endmodule

// File: rtl/seg_fault_classify.sv
module seg_fault_classify
  import segchk_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              real_mode,
  input  logic [ADDR_W-1:0] offset,
  input  logic [ADDR_W-1:0] limit,
  input  logic              priv_ok,
  input  logic [PERM_W-1:0] perm,
  input  acc_e              acc,
  output fault_e            fault,
  output logic              grant
);
  logic in_limit;
  logic rights_ok;

  assign in_limit = (offset <= limit);

  always_comb begin
    unique case (acc)
      ACC_READ:  rights_ok = perm[PERM_RD];
      ACC_WRITE: rights_ok = perm[PERM_WR];
      ACC_EXEC:  rights_ok = perm[PERM_EX];
      default:   rights_ok = 1'b0;
    endcase
  end

  // priority: limit, then privilege, then permission
  always_comb begin
    if (real_mode)       fault = FLT_NONE;
    else if (!in_limit)  fault = FLT_LIMIT;
    else if (!priv_ok)   fault = FLT_PRIV;
    else if (!rights_ok) fault = FLT_RIGHTS;
    else                 fault = FLT_NONE;
  end

  assign grant = (fault == FLT_NONE);
endmodule

// File: rtl/seg_prot_checker.sv
module seg_prot_checker
  import segchk_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int PL_W     = 2,
  parameter int RM_SEG_W = 16,
  parameter int RM_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              real_mode,
  input  logic [ADDR_W-1:0] desc_base,
  input  logic [ADDR_W-1:0] desc_limit,
  input  logic [PL_W-1:0]   desc_dpl,
  input  logic [2:0]        desc_perm,
  input  logic [PL_W-1:0]   sel_rpl,
  input  logic [PL_W-1:0]   cur_pl,
  input  logic [1:0]        acc_type,
  input  logic [ADDR_W-1:0] req_offset,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              rsp_grant,
  output logic [1:0]        rsp_fault
);
  localparam int RM_ADDR_W = RM_SEG_W + RM_SHIFT;

  logic [ADDR_W-1:0] lin_addr;
  logic              priv_ok;
  fault_e            fault_c;
  logic              grant_c;
  logic              accept;

  seg_addr_gen #(
    .ADDR_W(ADDR_W), .RM_SEG_W(RM_SEG_W), .RM_SHIFT(RM_SHIFT)
  ) u_addr (
    .real_mode(real_mode), .base(desc_base), .offset(req_offset),
    .lin_addr(lin_addr)
  );

  seg_priv_check #(.PL_W(PL_W)) u_priv (
    .rpl(sel_rpl), .cpl(cur_pl), .dpl(desc_dpl), .priv_ok(priv_ok)
  );

  seg_fault_classify #(.ADDR_W(ADDR_W)) u_cls (
    .real_mode(real_mode), .offset(req_offset), .limit(desc_limit),
    .priv_ok(priv_ok), .perm(desc_perm), .acc(acc_e'(acc_type)),
    .fault(fault_c), .grant(grant_c)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
      rsp_grant <= 1'b0;
      rsp_fault <= FLT_NONE;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_addr  <= lin_addr;
      rsp_grant <= grant_c;
      rsp_fault <= fault_c;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  p_prot_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !real_mode) |=> (rsp_addr == $past(desc_base + req_offset)));

  p_real_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && real_mode) |=> (rsp_grant && ((rsp_addr >> RM_ADDR_W) == '0)));

  p_limit_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !real_mode && (req_offset > desc_limit)) |=> (rsp_fault == FLT_LIMIT));

  p_grant_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_grant == (rsp_fault == FLT_NONE)));

  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr)
                                   && $stable(rsp_grant) && $stable(rsp_fault)));
endmodule

// File: tb/seg_prot_checker_tb.sv
module seg_prot_checker_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0;
  logic        req_ready;
  logic        real_mode = 0;
  logic [31:0] desc_base = 0;
  logic [31:0] desc_limit = 0;
  logic [1:0]  desc_dpl = 0;
  logic [2:0]  desc_perm = 0;
  logic [1:0]  sel_rpl = 0;
  logic [1:0]  cur_pl = 0;
  logic [1:0]  acc_type = 0;
  logic [31:0] req_offset = 0;
  logic        rsp_valid;
  logic        rsp_ready = 1;
  logic [31:0] rsp_addr;
  logic        rsp_grant;
  logic [1:0]  rsp_fault;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_prot_checker u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .real_mode(real_mode), .desc_base(desc_base), .desc_limit(desc_limit),
    .desc_dpl(desc_dpl), .desc_perm(desc_perm), .sel_rpl(sel_rpl),
    .cur_pl(cur_pl), .acc_type(acc_type), .req_offset(req_offset),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr),
    .rsp_grant(rsp_grant), .rsp_fault(rsp_fault)
  );

  function automatic logic [33:0] model(input logic rm, input logic [31:0] base,
      input logic [31:0] lim, input logic [31:0] off, input logic [1:0] dpl,
      input logic [1:0] rpl, input logic [1:0] cpl, input logic [1:0] typ,
      input logic [2:0] perm);
    logic [31:0] a;
    logic [19:0] r;
    logic [1:0]  f;
    logic [1:0]  eff;
    logic        rok;
    if (rm) begin
      r = {base[15:0], 4'h0} + {4'h0, off[15:0]};
      a = {12'h0, r};
      f = 2'b00;
    end else begin
      a   = base + off;
      eff = (rpl > cpl) ? rpl : cpl;
      rok = (typ == 2'd0) ? perm[0] : (typ == 2'd1) ? perm[1] :
            (typ == 2'd2) ? perm[2] : 1'b0;
      if (off > lim)      f = 2'b01;
      else if (eff > dpl) f = 2'b10;
      else if (!rok)      f = 2'b11;
      else                f = 2'b00;
    end
    return {f, a};
  endfunction

  task automatic check(input string tag, input logic ok, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic rm, input logic [31:0] base, input logic [31:0] lim,
      input logic [31:0] off, input logic [1:0] dpl, input logic [1:0] rpl,
      input logic [1:0] cpl, input logic [1:0] typ, input logic [2:0] perm);
    real_mode = rm; desc_base = base; desc_limit = lim; req_offset = off;
    desc_dpl = dpl; sel_rpl = rpl; cur_pl = cpl; acc_type = typ; desc_perm = perm;
    req_valid = 1;
  endtask

  // request accepted at the next edge, response checked at the following negedge
  task automatic req_check(input string tag, input logic rm, input logic [31:0] base,
      input logic [31:0] lim, input logic [31:0] off, input logic [1:0] dpl,
      input logic [1:0] rpl, input logic [1:0] cpl, input logic [1:0] typ,
      input logic [2:0] perm);
    logic [33:0] e;
    e = model(rm, base, lim, off, dpl, rpl, cpl, typ, perm);
    @(negedge clk);
    drive(rm, base, lim, off, dpl, rpl, cpl, typ, perm);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    check({tag, " R8 valid"}, rsp_valid == 1'b1, 64'(rsp_valid), 64'd1);
    check({tag, " addr"}, rsp_addr == e[31:0], 64'(rsp_addr), 64'(e[31:0]));
    check({tag, " fault"}, rsp_fault == e[33:32], 64'(rsp_fault), 64'(e[33:32]));
    check({tag, " R7 grant"}, rsp_grant == (e[33:32] == 2'b00), 64'(rsp_grant),
          64'(e[33:32] == 2'b00));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [33:0] ea;
    logic [33:0] eb;
    void'($urandom(32'd20250226));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    check("R10 valid", rsp_valid == 0, 64'(rsp_valid), 0);
    check("R10 grant", rsp_grant == 0, 64'(rsp_grant), 0);
    check("R10 fault", rsp_fault == 0, 64'(rsp_fault), 0);
    check("R10 ready", req_ready == 1, 64'(req_ready), 1);
    rst_n = 1;

    // R1 protected sum with 32-bit wrap
    req_check("R1 wrap", 0, 32'hFFFF_FFF0, 32'hFFFF_FFFF, 32'h20, 3, 0, 0, 0, 3'b001);
    req_check("R1 plain", 0, 32'h0040_0000, 32'h0000_FFFF, 32'h1234, 0, 0, 0, 2, 3'b100);
    // R2 legacy mode: 20-bit wrap, checks ignored
    req_check("R2 wrap", 1, 32'hABCD_FFFF, 32'h0, 32'hFFFF_0010, 0, 3, 3, 2'b11, 3'b000);
    req_check("R2 plain", 1, 32'h0000_1234, 32'h0, 32'h0000_0056, 0, 3, 3, 1, 3'b000);
    // R3 privilege max rule
    req_check("R3 rpl", 0, 32'h1000, 32'hFF, 32'h10, 2, 3, 0, 0, 3'b111);
    req_check("R3 cpl", 0, 32'h1000, 32'hFF, 32'h10, 1, 0, 2, 0, 3'b111);
    req_check("R3 pass", 0, 32'h1000, 32'hFF, 32'h10, 2, 2, 1, 0, 3'b111);
    // R4 permissions
    req_check("R4 wr ro", 0, 32'h2000, 32'hFF, 32'h4, 3, 3, 3, 1, 3'b101);
    req_check("R4 rsvd", 0, 32'h2000, 32'hFF, 32'h4, 3, 3, 3, 3, 3'b111);
    req_check("R4 ex", 0, 32'h2000, 32'hFF, 32'h4, 3, 3, 3, 2, 3'b100);
    // R5 limit boundary
    req_check("R5 eq", 0, 32'h3000, 32'h80, 32'h80, 0, 0, 0, 0, 3'b001);
    req_check("R5 over", 0, 32'h3000, 32'h80, 32'h81, 0, 0, 0, 0, 3'b001);
    // R6 priority
    req_check("R6 all", 0, 32'h3000, 32'h80, 32'h90, 0, 3, 3, 1, 3'b000);
    req_check("R6 priv", 0, 32'h3000, 32'h80, 32'h10, 0, 3, 3, 1, 3'b000);

    // R8 valid drops after drain with no new request
    @(negedge clk);
    check("R8 idle", rsp_valid == 0, 64'(rsp_valid), 0);

    // R9 back-pressure
    rsp_ready = 0;
    ea = model(0, 32'h5000, 32'hFF, 32'h8, 0, 0, 0, 0, 3'b001);
    eb = model(0, 32'h6000, 32'h4, 32'h8, 0, 0, 0, 0, 3'b001);
    drive(0, 32'h5000, 32'hFF, 32'h8, 0, 0, 0, 0, 3'b001);
    @(posedge clk);
    @(negedge clk);
    drive(0, 32'h6000, 32'h4, 32'h8, 0, 0, 0, 0, 3'b001);
    #1;
    check("R9 ready low", req_ready == 0, 64'(req_ready), 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 hold valid", rsp_valid == 1, 64'(rsp_valid), 1);
    check("R9 hold addr", rsp_addr == ea[31:0], 64'(rsp_addr), 64'(ea[31:0]));
    check("R9 hold fault", rsp_fault == ea[33:32], 64'(rsp_fault), 64'(ea[33:32]));
    rsp_ready = 1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    check("R9 next addr", rsp_addr == eb[31:0], 64'(rsp_addr), 64'(eb[31:0]));
    check("R9 next fault", rsp_fault == eb[33:32], 64'(rsp_fault), 64'(eb[33:32]));

    // random mix covering R1..R7
    for (int i = 0; i < 400; i++) begin
      logic [31:0] b;
      logic [31:0] l;
      logic [31:0] o;
      b = $urandom;
      l = $urandom;
      o = ($urandom % 4 == 0) ? l + 32'($urandom % 3) - 1 : $urandom;
      req_check("R1-7 rand", 1'($urandom % 5 == 0), b, l, o, 2'($urandom),
                2'($urandom), 2'($urandom), 2'($urandom), 3'($urandom));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule